// File: doc/BRIEF.md
# Two-Wire Bus Register Port

This block is a byte-oriented slave on a two-wire serial bus (one clock line, one open-drain data line). It gives a bus master access to a small register file through an internal word pointer. The block samples both bus lines with a faster system clock and recognises start, repeated start and stop conditions in that clock domain. It checks the 7-bit slave address and acknowledges the bytes it accepts. On reads it shifts register contents out most-significant bit first.

A write transfer first loads the word pointer. Each further byte is presented as a one-cycle write strobe at the pointer. A read transfer streams bytes from the pointer. It can follow a pointer write through a repeated start, or it can start directly and continue from the pointer left by the previous access. The block flags to the clock core when a read data phase is active. A power-fail input aborts any transfer and clears the pointer. The register file sits outside the block and returns read data combinationally for the presented address.

Top module: `twi_regport`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 7'h68, so 0xD0 selects write and 0xD1 selects read (bit 0 is the direction, 1 = read). Any other address is left unacknowledged. Later bytes are then ignored (no acknowledge, no write strobe) until the next start.
- R2: A falling data line while the clock line is high is a start. A rising data line while the clock line is high is a stop. Without a preceding start, clocked bytes get no acknowledge. The block changes its data drive only while the synchronized clock line is low.
- R3: In a write transfer, the first byte after the address is acknowledged, and its low three bits load the word pointer.
- R4: Every following written byte is acknowledged and produces one write strobe carrying that byte at the pointer. The pointer advances after the strobe and wraps from 7 to 0.
- R5: After a read address, the block drives the byte at the pointer most-significant bit first. The pointer advances only when the master acknowledges (data line low on the ninth clock).
- R6: A master NACK ends the read. The data line is released, and the read-active flag drops.
- R7: A read that is not preceded by a pointer write in the same transfer starts at the last stored pointer value.
- R8: While power-fail is high, the transfer is aborted, the pointer is cleared to 0, the data line is released, and bus activity is ignored.
- R9: The read-active flag is high during the data phase of a read transfer. It is never high together with a write strobe.
- R10: After reset the data line is released, no strobe is active and the read-active flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level as seen on the wire |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| pwrFail | input | 1 | Supply out of tolerance; aborts and deselects |
| regAddr | output | 3 | Word pointer, address for register access |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Byte to write |
| regRdEn | output | 1 | One-cycle pulse when a read byte is captured |
| regRdData | input | 8 | Register contents at regAddr |
| readActive | output | 1 | High during the read data phase |

## Verification
The main function is tried with four kinds of transfer. Plain writes with a pointer below 6 show that the pointer loads and steps. A write burst starting at 6 shows the wrap from 7 to 0. A combined read with a repeated start shows that the pointer is honoured across the restart. Bare current-address reads separate acknowledge-driven advance from NACK-held pointers. Wrong addresses, bytes clocked without a start, and a power-fail in the middle of a write show which conditions silence the slave and reset its pointer.

// File: rtl/twi_regport_pkg.sv
package twi_regport_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_RWAIT
  } busState_t;

  typedef enum logic [1:0] {
    DRV_KEEP,
    DRV_REL,
    DRV_ACK,
    DRV_DATA
  } drvSel_t;

  typedef struct packed {
    logic    clrCnt;
    logic    shiftIn;
    logic    countBit;
    logic    loadRd;
    logic    shiftOut;
    logic    ptrLoad;
    logic    ptrInc;
    logic    ptrClr;
    drvSel_t drv;
  } dpStrobe_t;

endpackage

// File: rtl/twi_regport_sync.sv
module twi_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;
  logic sclPrev, sdaPrev;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawLines[g]};
    end
    assign syncLines[g] = chain[STAGES-1];
  end

  assign sclLvl = syncLines[1];
  assign sdaLvl = syncLines[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  // both conditions need the clock line high on both samples
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/twi_regport_dp.sv
module twi_regport_dp
  import twi_regport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaBit,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteDone,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaDriveLow
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              nextMsb;

  assign nextMsb = strb.loadRd ? regRdData[DATA_W-1] : shiftReg[DATA_W-2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      bitCnt      <= '0;
      ptr         <= '0;
      sdaDriveLow <= 1'b0;
    end else begin
      if (strb.clrCnt)                       bitCnt <= '0;
      else if (strb.shiftIn || strb.countBit) bitCnt <= bitCnt + CNT_W'(1);

      if (strb.loadRd)        shiftReg <= regRdData;
      else if (strb.shiftIn)  shiftReg <= {shiftReg[DATA_W-2:0], sdaBit};
      else if (strb.shiftOut) shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};

      if (strb.ptrClr)       ptr <= '0;
      else if (strb.ptrLoad) ptr <= shiftReg[ADDR_W-1:0];
      else if (strb.ptrInc)  ptr <= ptr + ADDR_W'(1);

      case (strb.drv)
        DRV_REL:  sdaDriveLow <= 1'b0;
        DRV_ACK:  sdaDriveLow <= 1'b1;
        DRV_DATA: sdaDriveLow <= ~nextMsb;
        default:  sdaDriveLow <= sdaDriveLow;
      endcase
    end
  end

  assign rxByte   = shiftReg;
  assign byteDone = (bitCnt == CNT_W'(DATA_W));

endmodule

// File: rtl/twi_regport_ctrl.sv
module twi_regport_ctrl
  import twi_regport_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-2:0] SLAVE_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrFail,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaBit,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxByte,
  output dpStrobe_t         strb,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              readActive
);
  busState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    regWrEn  = 1'b0;
    if (pwrFail) begin
      stateNxt    = ST_IDLE;
      strb.ptrClr = 1'b1;
      strb.clrCnt = 1'b1;
      strb.drv    = DRV_REL;
    end else if (startSeen) begin
      stateNxt    = ST_ADDR;
      strb.clrCnt = 1'b1;
      strb.drv    = DRV_REL;
    end else if (stopSeen) begin
      stateNxt = ST_IDLE;
      strb.drv = DRV_REL;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (sclFall && byteDone) begin
            if (rxByte[DATA_W-1:1] == SLAVE_ADDR) begin
              stateNxt = ST_AACK;
              strb.drv = DRV_ACK;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            strb.clrCnt = 1'b1;
            if (rxByte[0]) begin
              stateNxt    = ST_RDATA;
              strb.loadRd = 1'b1;
              strb.drv    = DRV_DATA;
            end else begin
              stateNxt = ST_PTR;
              strb.drv = DRV_REL;
            end
          end
        end
        ST_PTR: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (sclFall && byteDone) begin
            stateNxt = ST_PACK;
            strb.drv = DRV_ACK;
          end
        end
        ST_PACK: begin
          if (sclRise) strb.ptrLoad = 1'b1;
          else if (sclFall) begin
            stateNxt    = ST_WDATA;
            strb.clrCnt = 1'b1;
            strb.drv    = DRV_REL;
          end
        end
        ST_WDATA: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (sclFall && byteDone) begin
            stateNxt = ST_WACK;
            strb.drv = DRV_ACK;
          end
        end
        ST_WACK: begin
          if (sclRise) begin
            regWrEn     = 1'b1;
            strb.ptrInc = 1'b1;
          end else if (sclFall) begin
            stateNxt    = ST_WDATA;
            strb.clrCnt = 1'b1;
            strb.drv    = DRV_REL;
          end
        end
        ST_RDATA: begin
          if (sclRise) strb.countBit = 1'b1;
          else if (sclFall) begin
            if (byteDone) begin
              stateNxt = ST_RACK;
              strb.drv = DRV_REL;
            end else begin
              strb.shiftOut = 1'b1;
              strb.drv      = DRV_DATA;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            if (!sdaBit) begin
              stateNxt    = ST_RWAIT;
              strb.ptrInc = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_RWAIT: begin
          if (sclFall) begin
            stateNxt    = ST_RDATA;
            strb.loadRd = 1'b1;
            strb.clrCnt = 1'b1;
            strb.drv    = DRV_DATA;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  assign regRdEn    = strb.loadRd;
  assign readActive = (state == ST_RDATA) || (state == ST_RACK) || (state == ST_RWAIT);

endmodule

// File: rtl/twi_regport.sv
module twi_regport
  import twi_regport_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 3,
  parameter logic [DATA_W-2:0] SLAVE_ADDR  = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic              pwrFail,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData,
  output logic              readActive
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic byteDone;
  logic [DATA_W-1:0] rxByte;
  dpStrobe_t strb;

  twi_regport_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  twi_regport_ctrl #(.DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .pwrFail(pwrFail),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .sdaBit(sdaLvl), .byteDone(byteDone), .rxByte(rxByte),
    .strb(strb), .regWrEn(regWrEn), .regRdEn(regRdEn), .readActive(readActive)
  );

  twi_regport_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaLvl), .regRdData(regRdData),
    .rxByte(rxByte), .byteDone(byteDone), .ptr(regAddr), .sdaDriveLow(sdaDriveLow)
  );

  assign regWrData = rxByte;

endmodule

// File: rtl/twi_regport_chk.sv
module twi_regport_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrFail,
  input logic              sclLvl,
  input logic              sdaDriveLow,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              readActive
);
  a_r8_abort_release: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> (!sdaDriveLow && !regWrEn && !readActive));

  a_r8_pointer_cleared: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> (regAddr == '0));

  a_r4_pointer_steps: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !pwrFail) |=> (regAddr == ADDR_W'($past(regAddr) + 1)));

  a_r5_load_in_read: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !pwrFail) |=> readActive);

  a_r9_no_write_in_read: assert property (@(posedge clk) disable iff (!rstN)
    readActive |-> !regWrEn);

  a_r2_drive_with_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrFail && !$past(pwrFail) && (sdaDriveLow != $past(sdaDriveLow))) |-> !$past(sclLvl));

endmodule

bind twi_regport twi_regport_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .pwrFail(pwrFail), .sclLvl(sclLvl),
  .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .readActive(readActive)
);

// File: tb/tb_twi_regport.sv
module tb_twi_regport;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic pwrFail = 1'b0;
  logic sdaDriveLow, regWrEn, regRdEn, readActive;
  logic [2:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic sdaBus;
  logic [7:0] mem [8];
  logic [7:0] expMem [8];
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int expWrAddr [$];
  logic [7:0] expWrData [$];
  logic raSeen;

  always #4 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaDriveLow;
  assign regRdData = mem[regAddr];

  twi_regport dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaDriveLow(sdaDriveLow),
    .pwrFail(pwrFail), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .readActive(readActive)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // register file model plus per-clock comparison of write strobes
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      summary();
    end
    if (rstN && regWrEn) begin
      if (expWrAddr.size() == 0) begin
        check(1'b0, "R4", "unexpected write strobe", regAddr, 0);
      end else begin
        int ea;
        logic [7:0] ed;
        ea = expWrAddr.pop_front();
        ed = expWrData.pop_front();
        check(regAddr == 3'(ea), "R4", "write address", regAddr, ea);
        check(regWrData == ed, "R4", "write data", regWrData, ed);
      end
      mem[regAddr] = regWrData;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectWrite(input int a, input logic [7:0] d);
    expWrAddr.push_back(a);
    expWrData.push_back(d);
    expMem[a] = d;
  endtask

  task automatic startCond();
    sdaM = 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b0; tick(HALF);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(HALF);
      sclM = 1'b1; tick(HALF);
      sclM = 1'b0;
    end
    sdaM = 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF / 2);
    acked = !sdaBus;
    tick(HALF / 2);
    sclM = 1'b0; tick(HALF);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(HALF);
      sclM = 1'b1; tick(HALF / 2);
      b = {b[6:0], sdaBus};
      if (i == 0) raSeen = readActive;
      tick(HALF / 2);
      sclM = 1'b0;
    end
    sdaM = !giveAck; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sclM = 1'b0;
    sdaM = 1'b1; tick(HALF);
  endtask

  initial begin
    bit ack;
    logic [7:0] rd;
    for (int i = 0; i < 8; i++) begin
      mem[i] = 8'hA0 + 8'(i);
      expMem[i] = 8'hA0 + 8'(i);
    end
    tick(5);
    rstN = 1'b1;
    tick(3);
    // R10 reset state
    check(sdaDriveLow == 1'b0, "R10", "data line released", sdaDriveLow, 0);
    check(regWrEn == 1'b0, "R10", "no write strobe", regWrEn, 0);
    check(readActive == 1'b0, "R10", "read flag low", readActive, 0);

    // plain write: pointer 2, two bytes
    startCond();
    sendByte(8'hD0, ack); check(ack, "R1", "write address ack", ack, 1);
    sendByte(8'h02, ack); check(ack, "R3", "pointer byte ack", ack, 1);
    expectWrite(2, 8'h11);
    sendByte(8'h11, ack); check(ack, "R4", "data ack", ack, 1);
    expectWrite(3, 8'h22);
    sendByte(8'h22, ack); check(ack, "R4", "data ack", ack, 1);
    stopCond();
    check(expWrAddr.size() == 0, "R4", "pending writes", expWrAddr.size(), 0);

    // wrap burst from 6
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h06, ack); check(ack, "R3", "pointer byte ack", ack, 1);
    expectWrite(6, 8'h33); sendByte(8'h33, ack);
    expectWrite(7, 8'h44); sendByte(8'h44, ack);
    expectWrite(0, 8'h55); sendByte(8'h55, ack);
    expectWrite(1, 8'h66); sendByte(8'h66, ack); check(ack, "R4", "ack after wrap", ack, 1);
    stopCond();
    check(expWrAddr.size() == 0, "R4", "wrap writes done", expWrAddr.size(), 0);

    // combined read from 2 through repeated start
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h02, ack);
    startCond();
    sendByte(8'hD1, ack); check(ack, "R1", "read address ack", ack, 1);
    recvByte(1'b1, rd); check(rd == expMem[2], "R5", "read byte at 2", rd, expMem[2]);
    check(raSeen == 1'b1, "R9", "read flag during data", raSeen, 1);
    recvByte(1'b0, rd); check(rd == expMem[3], "R5", "read byte at 3", rd, expMem[3]);
    check(sdaDriveLow == 1'b0, "R6", "released after nack", sdaDriveLow, 0);
    check(readActive == 1'b0, "R6", "read flag after nack", readActive, 0);
    stopCond();

    // current-address read: nack held the pointer at 3
    startCond();
    sendByte(8'hD1, ack);
    recvByte(1'b0, rd); check(rd == expMem[3], "R7", "current read at 3", rd, expMem[3]);
    stopCond();
    startCond();
    sendByte(8'hD1, ack);
    recvByte(1'b1, rd); check(rd == expMem[3], "R7", "current read again", rd, expMem[3]);
    recvByte(1'b0, rd); check(rd == expMem[4], "R5", "advance on ack", rd, expMem[4]);
    stopCond();

    // wrong address is ignored until next start
    startCond();
    sendByte(8'hA0, ack); check(!ack, "R1", "foreign address nack", ack, 0);
    sendByte(8'h00, ack); check(!ack, "R1", "bytes ignored", ack, 0);
    stopCond();

    // bytes without a start get nothing
    sendByte(8'hD0, ack); check(!ack, "R2", "no start no ack", ack, 0);
    stopCond();
    startCond();
    sendByte(8'hD1, ack); check(ack, "R2", "start reopens", ack, 1);
    recvByte(1'b0, rd); check(rd == expMem[4], "R7", "pointer kept at 4", rd, expMem[4]);
    stopCond();

    // power fail mid write
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h05, ack);
    pwrFail = 1'b1;
    tick(3);
    check(regAddr == 3'd0, "R8", "pointer cleared", regAddr, 0);
    sendByte(8'h77, ack); check(!ack, "R8", "bus ignored", ack, 0);
    check(sdaDriveLow == 1'b0, "R8", "released", sdaDriveLow, 0);
    pwrFail = 1'b0;
    tick(3);
    stopCond();
    check(expWrAddr.size() == 0, "R8", "no write during abort", expWrAddr.size(), 0);
    startCond();
    sendByte(8'hD1, ack);
    recvByte(1'b0, rd); check(rd == expMem[0], "R8", "read from 0 after abort", rd, expMem[0]);
    stopCond();
    tick(10);
    summary();
  end

endmodule